// File: doc/BRIEF.md
# Hertz-and-Percent PWM Generator

This block produces one pulse-width-modulated digital output whose rate is given in hertz and whose high share is given in whole percent. From a fixed system clock rate it derives, by integer division, the number of clock cycles in one period and the number of cycles the output stays high at the start of that period. Range checks on the settings and error reporting are done by a validator upstream. That validator delivers an error flag, and the block forces its output low while the flag is set.

New rate and duty settings are taken in only at a period boundary, so a running waveform never shows a cut or stretched pulse. The enable and the error flag act at once and are not delayed to a boundary. Each inactive-to-active change starts a fresh period. That period uses the settings on the inputs at the time.

Top module: `hzpct_pwm`

## Requirements
- R1: With the block active and a non-zero rate `freq_hz_i`, the output pattern repeats every P = floor(CLK_HZ / freq_hz_i) clock cycles.
- R2: Within each period the output is high for the first H = floor(P × duty_pct_i / 100) cycles and low for the remaining P − H cycles.
- R3: While `en_i` is 0 the output is low in that same cycle, whatever the other inputs are.
- R4: While `fault_i` is 1 the output is low in that same cycle, whatever the other inputs are.
- R5: A rate of 0 holds the output constantly low.
- R6: A duty of 0 holds the output low even while enabled. A duty of 100 holds it high for the whole period, with no low cycle.
- R7: A rate or duty change presented two or more cycles before the end of a period leaves the rest of that period unchanged. It applies from the first cycle of the next period.
- R8: When the block becomes active (en_i = 1 and fault_i = 0) after at least one inactive cycle, the first active cycle is cycle 0 of a new period. That period uses the settings that were held for at least two cycles beforehand.
- R9: While `rst` is high the output is low, and the block leaves reset with no period running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rate CLK_HZ |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Channel enable; 0 forces the output low at once |
| fault_i | input | 1 | Error flag from the upstream validator; 1 forces the output low at once |
| freq_hz_i | input | FREQ_W (16) | Output rate in hertz; 0 means constant low |
| duty_pct_i | input | DUTY_W (7) | High share in whole percent, 0 to 100 |
| pwm_o | output | 1 | Modulated output |

## Verification
Every window is checked cycle by cycle against a pattern that the bench computes on its own from P and H. Random rates between 500 Hz and 20 kHz, with random duties, exercise the integer rounding of both divisions. Directed cases use duties of 0, 1, 99 and 100 and a rate of 0, to separate the edge cases of the high-time formula from the constant-level rules. Mid-period setting changes show whether new values wait for the boundary. Dropping the enable or raising the error flag in the middle of a high phase shows whether the override is immediate, and the re-enable after it shows whether the counter restarts at cycle 0.

// File: rtl/hzpct_pkg.sv
package hzpct_pkg;

    // Width of the period and high-time counts
    localparam int unsigned TW = 32;
    localparam int unsigned PCT_FULL = 100;

    typedef struct packed {
        logic [TW-1:0] period;
        logic [TW-1:0] high_cnt;
    } pwm_timing_t;

    // Turns a rate in hertz and a duty in percent into clock-cycle counts
    function automatic pwm_timing_t derive_timing(
        input logic [63:0] clk_hz,
        input logic [63:0] freq,
        input logic [63:0] duty
    );
        pwm_timing_t t;
        logic [63:0] per;
        logic [63:0] hi;
        if (freq == 64'd0) begin
            per = 64'd0;
            hi  = 64'd0;
        end else begin
            per = clk_hz / freq;
            if (duty >= 64'(PCT_FULL))
                hi = per;
            else
                hi = (per * duty) / 64'(PCT_FULL);
        end
        t.period   = per[TW-1:0];
        t.high_cnt = hi[TW-1:0];
        return t;
    endfunction

endpackage

// File: rtl/hzpct_calc.sv
module hzpct_calc
    import hzpct_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned FREQ_W = 16,
    parameter int unsigned DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FREQ_W-1:0] freq_i,
    input  logic [DUTY_W-1:0] duty_i,
    output pwm_timing_t       pend_o
);

    pwm_timing_t calc_c;

    always_comb begin
        calc_c = derive_timing(64'(CLK_HZ), 64'(freq_i), 64'(duty_i));
    end

    // One register stage splits the dividers from the counter logic
    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= '0;
        else
            pend_o <= calc_c;
    end

endmodule

// File: rtl/hzpct_counter.sv
module hzpct_counter
    import hzpct_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  pwm_timing_t   next_i,
    output logic [TW-1:0] cnt_o,
    output pwm_timing_t   cur_o
);

    logic boundary;

    always_comb begin
        boundary = (cur_o.period == '0) || (cnt_o == cur_o.period - TW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            cur_o <= '0;
        end else if (!active_i) begin
            // Idle: stay at cycle 0 and keep picking up fresh settings
            cnt_o <= '0;
            cur_o <= next_i;
        end else if (boundary) begin
            cnt_o <= '0;
            cur_o <= next_i;
        end else begin
            cnt_o <= cnt_o + TW'(1);
        end
    end

endmodule

// File: rtl/hzpct_gate.sv
module hzpct_gate
    import hzpct_pkg::*;
(
    input  logic          active_i,
    input  logic [TW-1:0] cnt_i,
    input  logic [TW-1:0] high_i,
    output logic          pwm_o
);

    always_comb begin
        pwm_o = active_i && (cnt_i < high_i);
    end

endmodule

// File: rtl/hzpct_pwm.sv
module hzpct_pwm
    import hzpct_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned FREQ_W = 16,
    parameter int unsigned DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              fault_i,
    input  logic [FREQ_W-1:0] freq_hz_i,
    input  logic [DUTY_W-1:0] duty_pct_i,
    output logic              pwm_o
);

    logic          active;
    pwm_timing_t   pend_q;
    pwm_timing_t   cur_q;
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] per_q;
    logic [TW-1:0] hi_q;

    always_comb begin
        active = en_i && !fault_i;
        per_q  = cur_q.period;
        hi_q   = cur_q.high_cnt;
    end

    hzpct_calc #(
        .CLK_HZ (CLK_HZ),
        .FREQ_W (FREQ_W),
        .DUTY_W (DUTY_W)
    ) u_calc (
        .clk    (clk),
        .rst    (rst),
        .freq_i (freq_hz_i),
        .duty_i (duty_pct_i),
        .pend_o (pend_q)
    );

    hzpct_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .active_i (active),
        .next_i   (pend_q),
        .cnt_o    (cnt_q),
        .cur_o    (cur_q)
    );

    hzpct_gate u_gate (
        .active_i (active),
        .cnt_i    (cnt_q),
        .high_i   (hi_q),
        .pwm_o    (pwm_o)
    );

endmodule

// File: rtl/hzpct_pwm_chk.sv
module hzpct_pwm_chk
    import hzpct_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          en_i,
    input logic          fault_i,
    input logic          pwm_o,
    input logic          active,
    input logic [TW-1:0] cnt_q,
    input logic [TW-1:0] per_q,
    input logic [TW-1:0] hi_q
);

    // R3: disable wins over everything
    a_r3_disable_low: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> !pwm_o);

    // R4: error flag wins over everything
    a_r4_fault_low: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> !pwm_o);

    // R5: zero-length period never drives high
    a_r5_zero_period_low: assert property (@(posedge clk) disable iff (rst)
        (per_q == '0) |-> !pwm_o);

    // R1: the count stays inside the running period
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        (per_q != '0) |-> (cnt_q < per_q));

    // R7: settings only move when a new period begins
    a_r7_hold_midperiod: assert property (@(posedge clk) disable iff (rst)
        (active && cnt_q != '0) |-> ($stable(per_q) && $stable(hi_q)));

    // R8: an inactive cycle leaves the counter at period start
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt_q == '0));

endmodule

bind hzpct_pwm hzpct_pwm_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .fault_i (fault_i),
    .pwm_o   (pwm_o),
    .active  (active),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .hi_q    (hi_q)
);

// File: tb/hzpct_pwm_test.sv
`timescale 1ns/1ps
module hzpct_pwm_test;

    localparam int unsigned CLK_HZ_TB = 1_000_000;
    localparam int WATCHDOG_CYC = 190_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic        fault_i = 1'b0;
    logic [15:0] freq_hz_i = 16'd0;
    logic [6:0]  duty_pct_i = 7'd0;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hzpct_pwm #(.CLK_HZ(CLK_HZ_TB)) uut (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .fault_i    (fault_i),
        .freq_hz_i  (freq_hz_i),
        .duty_pct_i (duty_pct_i),
        .pwm_o      (pwm_o)
    );

    function automatic int exp_period(int f);
        if (f == 0) return 0;
        return int'(CLK_HZ_TB) / f;
    endfunction

    function automatic int exp_high(int p, int d);
        if (d >= 100) return p;
        return (p * d) / 100;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Samples n cycles, starting at phase ph of a period of p cycles with h high
    task automatic stream(int p, int h, int ph, int n, string tag);
        int bad = 0;
        int first_bad = -1;
        for (int i = 0; i < n; i++) begin
            bit e;
            #1;
            e = (p == 0) ? 1'b0 : (((ph + i) % p) < h);
            if (pwm_o !== e) begin
                bad++;
                if (first_bad < 0) first_bad = i;
            end
            @(negedge clk);
        end
        check(bad == 0, tag, bad, 0);
        if (bad != 0) $display("  first mismatching cycle %0d", first_bad);
    endtask

    // Idle the channel, present settings, let them settle
    task automatic configure(int f, int d);
        en_i = 1'b0;
        fault_i = 1'b0;
        freq_hz_i = 16'(f);
        duty_pct_i = 7'(d);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(int f, int d, string tag);
        int p = exp_period(f);
        int h = exp_high(p, d);
        configure(f, d);
        en_i = 1'b1;
        stream(p, h, 0, (p == 0) ? 50 : 2 * p, tag);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        @(negedge clk);
        en_i = 1'b1;
        freq_hz_i = 16'd1000;
        duty_pct_i = 7'd50;
        repeat (4) @(negedge clk);
        #1 check(pwm_o == 1'b0, "R9 output low in reset", int'(pwm_o), 0);
        rst = 1'b0;
        @(negedge clk);

        // Directed corner cases
        run_case(1000, 50, "R1 R2 1kHz 50pct");
        run_case(3000, 1, "R2 rounding duty 1");
        run_case(7000, 99, "R2 rounding duty 99");
        run_case(20000, 100, "R6 duty 100 stays high");
        run_case(2000, 0, "R6 duty 0 stays low");
        run_case(0, 60, "R5 rate 0 stays low");
        run_case(500, 37, "R1 R2 500Hz 37pct");

        // R7: mid-period change waits for the boundary
        begin
            int p1 = exp_period(4000);
            int h1 = exp_high(p1, 25);
            int p2 = exp_period(10000);
            int h2 = exp_high(p2, 80);
            configure(4000, 25);
            en_i = 1'b1;
            stream(p1, h1, 0, p1 / 2, "R8 start of first period");
            freq_hz_i = 16'd10000;
            duty_pct_i = 7'd80;
            stream(p1, h1, p1 / 2, p1 - p1 / 2, "R7 old period finishes unchanged");
            stream(p2, h2, 0, 2 * p2, "R7 new settings from next period");
        end

        // R3 and R8: disable inside a high phase, then restart at cycle 0
        begin
            int p = exp_period(2500);
            int h = exp_high(p, 60);
            configure(2500, 60);
            en_i = 1'b1;
            stream(p, h, 0, 10, "R8 run before disable");
            en_i = 1'b0;
            #1 check(pwm_o == 1'b0, "R3 disable is immediate", int'(pwm_o), 0);
            @(negedge clk);
            stream(p, 0, 0, 30, "R3 disabled stays low");
            en_i = 1'b1;
            stream(p, h, 0, 2 * p, "R8 re-enable restarts period");
        end

        // R4: error flag inside a high phase
        begin
            int p = exp_period(5000);
            int h = exp_high(p, 90);
            configure(5000, 90);
            en_i = 1'b1;
            stream(p, h, 0, 20, "R4 run before fault");
            fault_i = 1'b1;
            #1 check(pwm_o == 1'b0, "R4 fault is immediate", int'(pwm_o), 0);
            @(negedge clk);
            stream(p, 0, 0, 40, "R4 fault holds low");
            fault_i = 1'b0;
            stream(p, h, 0, 2 * p, "R4 R8 recovery after fault");
        end

        // Constrained random rates and duties
        for (int k = 0; k < 12; k++) begin
            int f = int'($urandom_range(20000, 500));
            int d = int'($urandom_range(100, 0));
            run_case(f, d, "R1 R2 random");
        end

        // R7 with a random pair of settings
        for (int k = 0; k < 3; k++) begin
            int fa = int'($urandom_range(20000, 1000));
            int da = int'($urandom_range(100, 0));
            int fb = int'($urandom_range(20000, 1000));
            int db = int'($urandom_range(100, 0));
            int pa = exp_period(fa);
            int pb = exp_period(fb);
            configure(fa, da);
            en_i = 1'b1;
            stream(pa, exp_high(pa, da), 0, pa / 3, "R7 random first part");
            freq_hz_i = 16'(fb);
            duty_pct_i = 7'(db);
            stream(pa, exp_high(pa, da), pa / 3, pa - pa / 3, "R7 random old tail");
            stream(pb, exp_high(pb, db), 0, 2 * pb, "R7 random new period");
        end

        en_i = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG_CYC, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule